// File: doc/BRIEF.md
# Transceiver channel reset sequencer

This block produces the digital reset for the transmit and receive side of a parameterised number of serial transceiver channels. It runs from one free-running system clock. It watches the PLL status (power-down request, lock, calibration busy) and, for each channel, TX calibration busy, RX calibration busy and CDR lock-to-data. A reset is released only after every condition that holds it has stayed clear for a programmable number of cycles. An RX ready flag per channel tells downstream logic when received data can be trusted.

Every status input crosses into the clock domain through a two-flop synchronizer before any decision uses it. Each channel has a TX mode and an RX mode, each either automatic or manual. The automatic modes restart the reset sequence when a lock is lost. The manual modes leave the reset released and let the surrounding logic decide. One parameter chooses whether the CDR lock inputs are combined into one shared status or used channel by channel. A second parameter chooses whether the block reset input acts asynchronously or is filtered synchronously.

Top module: `xrs_top`

## Requirements
- R1: While the internal reset is active, every `tx_rst` and `rx_rst` bit is 1 and every `rx_rdy` bit is 0. With SYNC_RST=0 this takes effect as soon as `rst_in` rises, and it lasts for as long as `rst_in` stays high.
- R2: With SYNC_RST=1, a pulse on `rst_in` that is high for only one clock cycle is ignored. A level that stays high for two cycles is honoured after the second rising edge.
- R3: `tx_rst[i]` is held at 1 while any of these is true: PLL power-down is high, PLL calibration busy is high, `tx_cal_busy[i]` is high, or PLL lock is low while channel i is in automatic TX mode (`tx_man_mode[i]`=0).
- R4: A reset is released only after its hold condition has been clear for a full count. For TX the count is TX_LOAD edges, and release comes 2+TX_LOAD rising edges after the input that cleared the last hold changes. For RX the count is RX_LOAD edges. A hold that reappears during the count reloads the counter, and the count then starts again from its full value.
- R5: After reset, no `tx_rst` bit is released until PLL lock has been seen high at least once. This applies in manual TX mode as well.
- R6: Once the first lock has been seen, a loss of PLL lock sets `tx_rst[i]` again if channel i is in automatic TX mode. If the channel is in manual TX mode, the loss is ignored.
- R7: `rx_rst[i]` is held at 1 while `rx_cal_busy[i]` is high, in either RX mode.
- R8: With SHARED_CDR=1, every channel sees the AND of all `cdr_lock` bits. With SHARED_CDR=0, channel i sees only `cdr_lock[i]`. Bit i of every vector port belongs to channel i.
- R9: In automatic RX mode (`rx_man_mode[i]`=0), a low CDR lock holds `rx_rst[i]` and clears `rx_rdy[i]`. `rx_rdy[i]` returns to 1 only after the RX count has completed.
- R10: In manual RX mode, the CDR lock has no effect on `rx_rst[i]`. `rx_rdy[i]` is 1 exactly when `rx_rst[i]` is released and the channel's CDR lock is high.
- R11: Every status input passes through a two-stage synchronizer. A CDR lock drop clears `rx_rdy` on the 2nd rising edge after the change, and a new hold sets its reset on the 3rd rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_in | input | 1 | Block reset, active high |
| pll_pwrdn | input | 1 | PLL power-down request |
| pll_lock | input | 1 | PLL lock status |
| pll_cal_busy | input | 1 | PLL calibration in progress |
| tx_cal_busy | input | NUM_CH | TX calibration in progress, per channel |
| rx_cal_busy | input | NUM_CH | RX calibration in progress, per channel |
| cdr_lock | input | NUM_CH | CDR locked to data, per channel |
| tx_man_mode | input | NUM_CH | 1 = manual TX mode, 0 = automatic |
| rx_man_mode | input | NUM_CH | 1 = manual RX mode, 0 = automatic |
| tx_rst | output | NUM_CH | TX digital reset, active high |
| rx_rst | output | NUM_CH | RX digital reset, active high |
| rx_rdy | output | NUM_CH | RX ready flag |

## Verification
Each status input reaches the decision logic on the second rising edge after it changes. A new hold therefore shows on a reset output at the third edge, and a CDR drop clears `rx_rdy` at the second edge. A TX release comes exactly 2+TX_LOAD edges after the last hold clears, and later still if a hold returns during the count. The bench drives every input on a falling edge, waits a counted number of rising edges, and samples on the next falling edge. The table rows wait twenty cycles, which is longer than any release time. The directed tests check the edge before and the edge of each timed transition, which covers the exact release, the counter reload, the ready drop and the two-cycle reset filter.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
   localparam int SYNC_STAGES = 2;

   typedef struct packed {
      logic pwrdn;
      logic lock;
      logic cal;
   } pll_stat_t;
endpackage

// File: rtl/xrs_sync2.sv
module xrs_sync2 #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/xrs_rst_cond.sv
module xrs_rst_cond #(
   parameter bit SYNC_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_in,
   output logic rst_o
);
   logic stg0, stg1;

   generate
      if (SYNC_RST) begin : g_sync
         // honoured only when the input is seen high on two edges in a row
         always_ff @(posedge clk) begin
            stg0 <= rst_in;
            stg1 <= rst_in & stg0;
         end
         assign rst_o = stg1;
      end else begin : g_async
         // immediate assertion, release aligned to the clock
         always_ff @(posedge clk or posedge rst_in) begin
            if (rst_in) begin
               stg0 <= 1'b0;
               stg1 <= 1'b0;
            end else begin
               stg0 <= 1'b1;
               stg1 <= stg0;
            end
         end
         assign rst_o = ~stg1;
      end
   endgenerate
endmodule

// File: rtl/xrs_countdown.sv
module xrs_countdown #(
   parameter int LOAD = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic hold,
   output logic rst_o
);
   localparam int CW = (LOAD < 2) ? 1 : $clog2(LOAD);
   localparam logic [CW-1:0] RELOAD = CW'(LOAD - 1);

   generate
      if (LOAD < 2) begin : g_bad_load
         $error("xrs_countdown: LOAD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt   <= RELOAD;
         rst_o <= 1'b1;
      end else if (hold) begin
         cnt   <= RELOAD;
         rst_o <= 1'b1;
      end else if (cnt != '0) begin
         cnt   <= cnt - CW'(1);
         rst_o <= 1'b1;
      end else begin
         rst_o <= 1'b0;
      end
   end

   // R3, R7: any hold keeps the output asserted on the next edge
   p_hold_forces_rst_r3: assert property (@(posedge clk) disable iff (rst)
      hold |=> rst_o);

   // R4: no release while the count is still running
   p_count_blocks_release_r4: assert property (@(posedge clk) disable iff (rst)
      (!hold && cnt != '0) |=> rst_o);

   // R4: a release follows an expired count with no hold present
   p_release_after_count_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(rst_o) |-> ($past(cnt) == '0 && !$past(hold)));
endmodule

// File: rtl/xrs_top.sv
module xrs_top #(
   parameter int NUM_CH     = 2,
   parameter int TX_LOAD    = 8,
   parameter int RX_LOAD    = 6,
   parameter bit SHARED_CDR = 1'b0,
   parameter bit SYNC_RST   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_in,
   input  logic              pll_pwrdn,
   input  logic              pll_lock,
   input  logic              pll_cal_busy,
   input  logic [NUM_CH-1:0] tx_cal_busy,
   input  logic [NUM_CH-1:0] rx_cal_busy,
   input  logic [NUM_CH-1:0] cdr_lock,
   input  logic [NUM_CH-1:0] tx_man_mode,
   input  logic [NUM_CH-1:0] rx_man_mode,
   output logic [NUM_CH-1:0] tx_rst,
   output logic [NUM_CH-1:0] rx_rst,
   output logic [NUM_CH-1:0] rx_rdy
);
   import xrs_pkg::*;

   localparam int PLL_W = $bits(pll_stat_t);
   localparam int SW    = PLL_W + 5 * NUM_CH;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("xrs_top: NUM_CH must be at least 1");
      end
      if (TX_LOAD < 2 || RX_LOAD < 2) begin : g_bad_load
         $error("xrs_top: TX_LOAD and RX_LOAD must be at least 2");
      end
   endgenerate

   logic rst_i;

   xrs_rst_cond #(.SYNC_RST(SYNC_RST)) u_rst (
      .clk    (clk),
      .rst_in (rst_in),
      .rst_o  (rst_i)
   );

   // ---- status synchronisation ----
   pll_stat_t         pll_raw, pll_s;
   logic [NUM_CH-1:0] tcal_s, rcal_s, cdr_s, tman_s, rman_s;
   logic [SW-1:0]     sync_d, sync_q;

   assign pll_raw = '{pwrdn: pll_pwrdn, lock: pll_lock, cal: pll_cal_busy};
   assign sync_d  = {pll_raw, tx_cal_busy, rx_cal_busy, cdr_lock,
                     tx_man_mode, rx_man_mode};

   xrs_sync2 #(.W(SW)) u_sync (
      .clk (clk),
      .rst (rst_i),
      .d   (sync_d),
      .q   (sync_q)
   );

   assign {pll_s, tcal_s, rcal_s, cdr_s, tman_s, rman_s} = sync_q;

   // ---- first PLL lock since reset ----
   logic pll_seen_q, pll_seen;

   always_ff @(posedge clk or posedge rst_i) begin
      if (rst_i) pll_seen_q <= 1'b0;
      else       pll_seen_q <= pll_seen;
   end
   assign pll_seen = pll_seen_q | pll_s.lock;

   // ---- CDR lock selection ----
   logic [NUM_CH-1:0] cdr_eff;

   generate
      if (SHARED_CDR) begin : g_cdr_shared
         assign cdr_eff = {NUM_CH{&cdr_s}};
      end else begin : g_cdr_split
         assign cdr_eff = cdr_s;
      end
   endgenerate

   // ---- per-channel sequencing ----
   logic pll_common_hold;
   assign pll_common_hold = pll_s.pwrdn | pll_s.cal | ~pll_seen;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic tx_hold, rx_hold;

         assign tx_hold = pll_common_hold | tcal_s[ch]
                        | (~pll_s.lock & ~tman_s[ch]);
         assign rx_hold = rcal_s[ch] | (~rman_s[ch] & ~cdr_eff[ch]);

         xrs_countdown #(.LOAD(TX_LOAD)) u_tx_cnt (
            .clk   (clk),
            .rst   (rst_i),
            .hold  (tx_hold),
            .rst_o (tx_rst[ch])
         );

         xrs_countdown #(.LOAD(RX_LOAD)) u_rx_cnt (
            .clk   (clk),
            .rst   (rst_i),
            .hold  (rx_hold),
            .rst_o (rx_rst[ch])
         );

         assign rx_rdy[ch] = ~rx_rst[ch] & cdr_eff[ch];

         // R5: without a first lock the TX reset stays asserted
         p_first_lock_r5: assert property (@(posedge clk) disable iff (rst_i)
            !pll_seen |=> tx_rst[ch]);

         // R6: automatic TX mode restarts on loss of lock
         p_auto_lock_loss_r6: assert property (@(posedge clk) disable iff (rst_i)
            (!pll_s.lock && !tman_s[ch]) |=> tx_rst[ch]);

         // R7: RX calibration gates the RX release
         p_rx_cal_gate_r7: assert property (@(posedge clk) disable iff (rst_i)
            rcal_s[ch] |=> rx_rst[ch]);

         // R10: a released manual RX channel stays released while calibration is idle
         p_manual_rx_keeps_r10: assert property (@(posedge clk) disable iff (rst_i)
            (rman_s[ch] && !rcal_s[ch] && !rx_rst[ch]) |=> !rx_rst[ch]);

         // R9: ready never rises in the same cycle as a reset release is pending
         p_rdy_after_release_r9: assert property (@(posedge clk) disable iff (rst_i)
            $rose(rx_rdy[ch]) |-> $past(!rx_hold));
      end
   endgenerate

   // R1: reset drives every output to its safe state
   p_rst_holds_r1: assert property (@(posedge clk)
      rst_i |=> (&tx_rst && &rx_rst && rx_rdy == '0));
endmodule

// File: tb/xrs_top_test.sv
module xrs_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 2;
   localparam int TXL        = 8;
   localparam int RXL        = 6;
   localparam int SETTLE     = 20;
   localparam int WDOG       = 20000;

   typedef struct packed {
      logic       lock, pwrdn, pcal;
      logic [1:0] tcal, rcal, cdr, tman, rman;
      logic [1:0] etx, erx, erdy, erx_s, erdy_s;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 15;
   // lock pwrdn pcal tcal rcal cdr tman rman | tx rx rdy rx_s rdy_s | req
   localparam vec_t TBL [0:NV-1] = '{
      '{1'b0,1'b0,1'b0,2'b00,2'b00,2'b11,2'b00,2'b00, 2'b11,2'b00,2'b11,2'b00,2'b11, 4'd5},  // R5 no lock yet
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b11,2'b00,2'b00, 2'b00,2'b00,2'b11,2'b00,2'b11, 4'd3},  // R3 all clear
      '{1'b0,1'b0,1'b0,2'b00,2'b00,2'b11,2'b00,2'b00, 2'b11,2'b00,2'b11,2'b00,2'b11, 4'd6},  // R6 auto loss
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b11,2'b00,2'b00, 2'b00,2'b00,2'b11,2'b00,2'b11, 4'd6},
      '{1'b0,1'b0,1'b0,2'b00,2'b00,2'b11,2'b01,2'b00, 2'b10,2'b00,2'b11,2'b00,2'b11, 4'd6},  // R6 ch0 manual
      '{1'b1,1'b0,1'b0,2'b10,2'b00,2'b11,2'b01,2'b00, 2'b10,2'b00,2'b11,2'b00,2'b11, 4'd3},  // R3 tx cal ch1
      '{1'b1,1'b0,1'b1,2'b00,2'b00,2'b11,2'b01,2'b00, 2'b11,2'b00,2'b11,2'b00,2'b11, 4'd3},  // R3 pll cal
      '{1'b1,1'b1,1'b0,2'b00,2'b00,2'b11,2'b01,2'b00, 2'b11,2'b00,2'b11,2'b00,2'b11, 4'd3},  // R3 power-down
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b11,2'b01,2'b00, 2'b00,2'b00,2'b11,2'b00,2'b11, 4'd3},
      '{1'b1,1'b0,1'b0,2'b00,2'b01,2'b11,2'b01,2'b00, 2'b00,2'b01,2'b10,2'b01,2'b10, 4'd7},  // R7 rx cal ch0
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b10,2'b01,2'b00, 2'b00,2'b01,2'b10,2'b11,2'b00, 4'd9},  // R9 / R8 shared
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b10,2'b01,2'b01, 2'b00,2'b00,2'b10,2'b10,2'b00, 4'd10}, // R10 ch0 manual
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b11,2'b01,2'b01, 2'b00,2'b00,2'b11,2'b00,2'b11, 4'd10},
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b01,2'b01,2'b00, 2'b00,2'b10,2'b01,2'b11,2'b00, 4'd8},  // R8 split vs shared
      '{1'b1,1'b0,1'b0,2'b00,2'b00,2'b11,2'b01,2'b00, 2'b00,2'b00,2'b11,2'b00,2'b11, 4'd9}
   };

   logic clk = 1'b0;
   logic rst_a = 1'b1, rst_s = 1'b1;
   logic lock = 1'b0, pwrdn = 1'b0, pcal = 1'b0;
   logic [N-1:0] tcal = '0, rcal = '0, cdr = '1, tman = '0, rman = '0;
   logic [N-1:0] tx_a, rx_a, rdy_a, tx_s, rx_s, rdy_s;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xrs_top #(.NUM_CH(N), .TX_LOAD(TXL), .RX_LOAD(RXL),
             .SHARED_CDR(1'b0), .SYNC_RST(1'b0)) uut (
      .clk(clk), .rst_in(rst_a), .pll_pwrdn(pwrdn), .pll_lock(lock),
      .pll_cal_busy(pcal), .tx_cal_busy(tcal), .rx_cal_busy(rcal),
      .cdr_lock(cdr), .tx_man_mode(tman), .rx_man_mode(rman),
      .tx_rst(tx_a), .rx_rst(rx_a), .rx_rdy(rdy_a));

   xrs_top #(.NUM_CH(N), .TX_LOAD(TXL), .RX_LOAD(RXL),
             .SHARED_CDR(1'b1), .SYNC_RST(1'b1)) uut_s (
      .clk(clk), .rst_in(rst_s), .pll_pwrdn(pwrdn), .pll_lock(lock),
      .pll_cal_busy(pcal), .tx_cal_busy(tcal), .rx_cal_busy(rcal),
      .cdr_lock(cdr), .tx_man_mode(tman), .rx_man_mode(rman),
      .tx_rst(tx_s), .rx_rst(rx_s), .rx_rdy(rdy_s));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string what, input logic [N-1:0] got,
                      input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %b expected %b", what, got, exp);
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired got running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // ---- reset state, both variants (R1) ----
      step(5);
      chk("R1 tx during reset", tx_a, 2'b11);
      chk("R1 rx during reset", rx_a, 2'b11);
      chk("R1 rdy during reset", rdy_a, 2'b00);
      chk("R1 sync variant tx during reset", tx_s, 2'b11);
      chk("R1 sync variant rdy during reset", rdy_s, 2'b00);
      rst_a = 1'b0;
      rst_s = 1'b0;
      step(SETTLE);

      // ---- table walk ----
      for (int i = 0; i < NV; i++) begin
         lock  = TBL[i].lock;
         pwrdn = TBL[i].pwrdn;
         pcal  = TBL[i].pcal;
         tcal  = TBL[i].tcal;
         rcal  = TBL[i].rcal;
         cdr   = TBL[i].cdr;
         tman  = TBL[i].tman;
         rman  = TBL[i].rman;
         step(SETTLE);
         chk($sformatf("R%0d row %0d tx", TBL[i].req, i), tx_a, TBL[i].etx);
         chk($sformatf("R%0d row %0d rx", TBL[i].req, i), rx_a, TBL[i].erx);
         chk($sformatf("R%0d row %0d rdy", TBL[i].req, i), rdy_a, TBL[i].erdy);
         chk($sformatf("R%0d row %0d shared rx", TBL[i].req, i), rx_s, TBL[i].erx_s);
         chk($sformatf("R%0d row %0d shared rdy", TBL[i].req, i), rdy_s, TBL[i].erdy_s);
      end

      // ---- R11: CDR drop reaches rdy on the 2nd edge, rx_rst on the 3rd ----
      cdr = 2'b01;
      step(1);
      chk("R11 rdy after one edge", rdy_a, 2'b11);
      step(1);
      chk("R11 rdy after two edges", rdy_a, 2'b01);
      step(1);
      chk("R11 rx_rst after three edges", rx_a, 2'b10);
      cdr = 2'b11;
      step(SETTLE);

      // ---- R4: exact TX release at 2+TX_LOAD edges ----
      tman = 2'b00;
      lock = 1'b0;
      step(SETTLE);
      lock = 1'b1;
      step(2 + TXL - 1);
      chk("R4 tx one edge before release", tx_a, 2'b11);
      step(1);
      chk("R4 tx at release edge", tx_a, 2'b00);

      // ---- R4: a one-cycle lock glitch reloads the counter ----
      lock = 1'b0;
      step(SETTLE);
      lock = 1'b1;
      step(5);
      lock = 1'b0;
      step(1);
      lock = 1'b1;
      step(9);
      chk("R4 reload tx before new release", tx_a, 2'b11);
      step(1);
      chk("R4 reload tx at new release", tx_a, 2'b00);

      // ---- R1 async, R5 and R6 manual ----
      tman = 2'b11;
      lock = 1'b0;
      @(posedge clk);
      #(CLK_PERIOD/4);
      rst_a = 1'b1;
      #1;
      chk("R1 tx immediately on async reset", tx_a, 2'b11);
      chk("R1 rdy immediately on async reset", rdy_a, 2'b00);
      step(3);
      chk("R1 rx held while reset held", rx_a, 2'b11);
      rst_a = 1'b0;
      step(SETTLE);
      chk("R5 manual tx waits for first lock", tx_a, 2'b11);
      lock = 1'b1;
      step(SETTLE);
      chk("R5 manual tx released after first lock", tx_a, 2'b00);
      lock = 1'b0;
      step(SETTLE);
      chk("R6 manual tx ignores later loss", tx_a, 2'b00);
      lock = 1'b1;
      step(SETTLE);

      // ---- R2: synchronous reset filter ----
      chk("R2 sync variant released before pulse", tx_s, 2'b00);
      rst_s = 1'b1;
      step(1);
      rst_s = 1'b0;
      step(3);
      chk("R2 one-cycle pulse ignored", tx_s, 2'b00);
      chk("R2 one-cycle pulse ignored rdy", rdy_s, 2'b11);
      rst_s = 1'b1;
      step(2);
      chk("R2 two-cycle reset honoured tx", tx_s, 2'b11);
      chk("R2 two-cycle reset honoured rdy", rdy_s, 2'b00);
      chk("R2 async variant untouched", tx_a, 2'b00);
      rst_s = 1'b0;
      step(SETTLE);
      chk("R2 sync variant recovers", tx_s, 2'b00);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule